// File: doc/BRIEF.md
# Trigger-Tagged Acquisition Packer and Controller

This block sits between an ADC capture path and a memory writer. Each input word carries eight 8-bit samples plus a per-sample trigger vector from an upstream detector. A register stage turns each word into a 68-bit tagged entry: the 64 data bits, a flag that says whether any sample in the word triggered, and the 3-bit position of that sample. Only the 64 data bits leave on the memory stream, each with its own word address. The tag bits stay inside the block, where they drive the acquisition sequencer.

The sequencer runs waveforms back to back with no software in the loop. Each acquisition first collects a programmable number of pre-trigger words, then waits for a tagged word. It records one trigger pointer, which is the word address joined to the in-word sample position. It then collects a programmable number of post-trigger words. On completion it appends a descriptor holding the start address, the trigger pointer and the end address to a small hardware list, and the next acquisition begins at the very next word address. If the list has no room for another entry, the block raises a sticky overflow flag. It then consumes and discards incoming words until a slot frees, and never overwrites an unread descriptor.

The input, memory and descriptor interfaces are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. While valid is high and ready is low, the sender holds its payload unchanged. Back-pressure on the memory stream propagates to `s_ready` through the single register stage. While the block is halted, `s_ready` follows only the internal stage and never the memory stream.

Top module: `acq_tag_ctrl`

## Requirements
- R1: For each accepted input word, the tag flag is set exactly when any bit of `s_trig` is set. The 3-bit index is the lowest set bit position, where bit i of `s_trig` belongs to the sample in `s_data[8i+7:8i]`.
- R2: The memory stream carries the 64 input data bits unchanged and in input order. Addresses start at 0 after reset and rise by one per written word, wrapping modulo 2^16.
- R3: While `m_valid` is high and `m_ready` is low, `m_data` and `m_addr` hold their values. Back-pressure stalls the input, and no word is lost or duplicated.
- R4: The first `cfg_pre_len` words of an acquisition are pre-trigger words, and their trigger bits are ignored. When `cfg_pre_len` is 0, the first word can already trigger.
- R5: The trigger pointer is {word address, 3-bit index} (address in bits 18:3, index in bits 2:0) of the first tagged word after the pre-trigger words. Tags in later words of the same acquisition are ignored.
- R6: The end address of an acquisition is the trigger word address plus `cfg_post_len`. With `cfg_post_len` of 0, the trigger word is also the last word.
- R7: Each acquisition starts at the word address following the previous end, so consecutive descriptors leave no gap.
- R8: Descriptors leave in completion order on a valid/ready stream, with fields held stable while stalled.
- R9: When a completion fills the list, `overflow` rises and stays high until reset. Further words are accepted with no memory write until the list has room. Capture then resumes with a new acquisition starting at the first unwritten address.
- R10: After reset, `m_valid`, `d_valid` and `overflow` are low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre_len | input | 16 | Pre-trigger word count per acquisition |
| cfg_post_len | input | 16 | Post-trigger word count per acquisition |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word ready |
| s_data | input | 64 | Eight 8-bit samples, sample i in bits 8i+7:8i |
| s_trig | input | 8 | Per-sample trigger detections |
| m_valid | output | 1 | Memory write valid |
| m_ready | input | 1 | Memory write ready |
| m_addr | output | 16 | Memory word address |
| m_data | output | 64 | Sample data to memory |
| d_valid | output | 1 | Descriptor valid |
| d_ready | input | 1 | Descriptor ready |
| d_start | output | 16 | First word address of the acquisition |
| d_trig_ptr | output | 19 | Trigger word address and in-word index |
| d_end | output | 16 | Last word address of the acquisition |
| overflow | output | 1 | Sticky: the descriptor list filled and capture halted |

## Verification
The hardest condition to reach is the halt on a full descriptor list. It only occurs when several acquisitions complete while nobody reads descriptors, and words that arrive during the halt must vanish without touching memory. The stimulus uses pre-trigger 0 and post-trigger 1 with every word tagged, holds `d_ready` low, and sends more words than four acquisitions need. It then idles, checks `overflow` and the silent memory stream, and releases `d_ready`. Finally it resumes input and expects the next descriptor to start at the first unwritten address, while memory back-pressure toggles during the other phases.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_SEEK = 2'd0,
    ST_POST = 2'd1,
    ST_HALT = 2'd2
  } acq_state_e;
endpackage

// File: rtl/acq_tag_packer.sv
// One register stage that turns a sample word into a tagged entry.
module acq_tag_packer #(
  parameter int DW = 64,
  parameter int SW = 8,
  localparam int NS = DW / SW,
  localparam int IW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [NS-1:0] in_trig,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_flag,
  output logic [IW-1:0] out_idx
);
  localparam int EW = DW + 1 + IW;

  logic [EW-1:0] entry_q;
  logic [IW-1:0] low_idx;
  logic          any_hit;

  // priority: lowest sample position wins
  always_comb begin
    low_idx = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (in_trig[i]) low_idx = IW'(i);
    end
  end

  assign any_hit  = |in_trig;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      entry_q   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) entry_q <= {any_hit, low_idx, in_data};
    end
  end

  assign out_flag = entry_q[EW-1];
  assign out_idx  = entry_q[EW-2 -: IW];
  assign out_data = entry_q[DW-1:0];

  // R3: a stalled entry is held
  a_r3_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(entry_q));
endmodule

// File: rtl/acq_desc_queue.sv
// Circular list of finished acquisition descriptors.
module acq_desc_queue #(
  parameter int AW    = 16,
  parameter int PW    = 19,
  parameter int DEPTH = 4,
  localparam int QW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_start,
  input  logic [PW-1:0] push_tptr,
  input  logic [AW-1:0] push_end,
  output logic          d_valid,
  input  logic          d_ready,
  output logic [AW-1:0] d_start,
  output logic [PW-1:0] d_tptr,
  output logic [AW-1:0] d_end,
  output logic          full,
  output logic          near_full
);
  logic [AW-1:0] start_mem [DEPTH];
  logic [PW-1:0] tptr_mem  [DEPTH];
  logic [AW-1:0] end_mem   [DEPTH];
  logic [QW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop;

  assign pop       = d_valid && d_ready;
  assign d_valid   = count != '0;
  assign full      = count == CW'(DEPTH);
  assign near_full = count == CW'(DEPTH - 1);
  assign d_start   = start_mem[rd_ptr];
  assign d_tptr    = tptr_mem[rd_ptr];
  assign d_end     = end_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      start_mem[wr_ptr] <= push_start;
      tptr_mem[wr_ptr]  <= push_tptr;
      end_mem[wr_ptr]   <= push_end;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == QW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == QW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R9: an unread descriptor is never overwritten
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8: stalled descriptor holds
  a_r8_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && !d_ready |=> d_valid && $stable(d_start) && $stable(d_tptr) && $stable(d_end));
endmodule

// File: rtl/acq_sequencer.sv
// Pre/trigger/post sequencing, address generation and descriptor issue.
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 3,
  parameter int CW = 16,
  localparam int PW = AW + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_pre,
  input  logic [CW-1:0] cfg_post,
  input  logic          pk_valid,
  output logic          pk_ready,
  input  logic          pk_flag,
  input  logic [IW-1:0] pk_idx,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [AW-1:0] m_addr,
  output logic          push,
  output logic [AW-1:0] push_start,
  output logic [PW-1:0] push_tptr,
  output logic [AW-1:0] push_end,
  input  logic          q_full,
  input  logic          q_near_full,
  input  logic          q_pop,
  output logic          overflow
);
  acq_state_e    st;
  logic [AW-1:0] wr_addr, acq_start;
  logic [CW-1:0] pre_cnt, post_cnt;
  logic [PW-1:0] tptr_q, cur_ptr;
  logic          beat, armed, hit, post_done, finish, full_after;

  assign pk_ready   = m_ready || (st == ST_HALT);
  assign m_valid    = pk_valid && (st != ST_HALT);
  assign m_addr     = wr_addr;
  assign beat       = pk_valid && pk_ready && (st != ST_HALT);
  assign armed      = pre_cnt >= cfg_pre;
  assign hit        = (st == ST_SEEK) && armed && pk_flag;
  assign post_done  = (st == ST_POST) && (({1'b0, post_cnt} + 1'b1) >= {1'b0, cfg_post});
  assign finish     = beat && ((hit && cfg_post == '0) || post_done);
  assign full_after = q_near_full && !q_pop;
  assign cur_ptr    = {wr_addr, pk_idx};

  assign push       = finish;
  assign push_start = acq_start;
  assign push_tptr  = (st == ST_SEEK) ? cur_ptr : tptr_q;
  assign push_end   = wr_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_SEEK;
      wr_addr   <= '0;
      acq_start <= '0;
      pre_cnt   <= '0;
      post_cnt  <= '0;
      tptr_q    <= '0;
      overflow  <= 1'b0;
    end else if (st == ST_HALT) begin
      pre_cnt <= '0;
      if (!q_full) st <= ST_SEEK;
    end else if (beat) begin
      wr_addr <= wr_addr + 1'b1;
      if (finish) begin
        acq_start <= wr_addr + 1'b1;
        pre_cnt   <= '0;
        post_cnt  <= '0;
        if (full_after) begin
          st       <= ST_HALT;
          overflow <= 1'b1;
        end else begin
          st <= ST_SEEK;
        end
      end else if (hit) begin
        tptr_q   <= cur_ptr;
        post_cnt <= '0;
        st       <= ST_POST;
      end else if (st == ST_POST) begin
        post_cnt <= post_cnt + 1'b1;
      end else if (!armed) begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  // helper distances for the window check (modulo address space)
  logic [AW-1:0] trig_off, span;
  assign trig_off = push_tptr[PW-1:IW] - push_start;
  assign span     = push_end - push_start;

  // R9: flag is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R9: overflow only rises when the list is really full
  a_r9_rise_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> q_full);
  // R5: trigger lies inside its acquisition window
  a_r5_trig_inside: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> trig_off <= span);
  // R3: memory write held under back-pressure
  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr));
endmodule

// File: rtl/acq_tag_ctrl.sv
module acq_tag_ctrl #(
  parameter int DW    = 64,
  parameter int SW    = 8,
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  localparam int NS = DW / SW,
  localparam int IW = $clog2(NS),
  localparam int PW = AW + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_pre_len,
  input  logic [CW-1:0] cfg_post_len,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic [NS-1:0] s_trig,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_data,
  output logic          d_valid,
  input  logic          d_ready,
  output logic [AW-1:0] d_start,
  output logic [PW-1:0] d_trig_ptr,
  output logic [AW-1:0] d_end,
  output logic          overflow
);
  logic          pk_valid, pk_ready, pk_flag;
  logic [IW-1:0] pk_idx;
  logic          push, q_full, q_near_full, q_pop;
  logic [AW-1:0] push_start, push_end;
  logic [PW-1:0] push_tptr;

  assign q_pop = d_valid && d_ready;

  acq_tag_packer #(.DW(DW), .SW(SW)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data), .in_trig(s_trig),
    .out_valid(pk_valid), .out_ready(pk_ready), .out_data(m_data),
    .out_flag(pk_flag), .out_idx(pk_idx)
  );

  acq_sequencer #(.AW(AW), .IW(IW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_pre(cfg_pre_len), .cfg_post(cfg_post_len),
    .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_flag(pk_flag), .pk_idx(pk_idx),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
    .push(push), .push_start(push_start), .push_tptr(push_tptr), .push_end(push_end),
    .q_full(q_full), .q_near_full(q_near_full), .q_pop(q_pop),
    .overflow(overflow)
  );

  acq_desc_queue #(.AW(AW), .PW(PW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_start(push_start), .push_tptr(push_tptr), .push_end(push_end),
    .d_valid(d_valid), .d_ready(d_ready),
    .d_start(d_start), .d_tptr(d_trig_ptr), .d_end(d_end),
    .full(q_full), .near_full(q_near_full)
  );
endmodule

// File: tb/sim_acq_tag_ctrl.sv
`timescale 1ns/1ps
module sim_acq_tag_ctrl;
  localparam int AW = 16;
  localparam int PW = 19;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_pre = 16'd2, cfg_post = 16'd3;
  logic        s_valid = 1'b0, s_ready;
  logic [63:0] s_data = '0;
  logic [7:0]  s_trig = '0;
  logic        m_valid, m_ready = 1'b1;
  logic [15:0] m_addr;
  logic [63:0] m_data;
  logic        d_valid, d_ready = 1'b1;
  logic [15:0] d_start, d_end;
  logic [18:0] d_trig_ptr;
  logic        overflow;

  always #4 clk = ~clk;

  acq_tag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pre_len(cfg_pre), .cfg_post_len(cfg_post),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_trig(s_trig),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
    .d_valid(d_valid), .d_ready(d_ready), .d_start(d_start), .d_trig_ptr(d_trig_ptr),
    .d_end(d_end), .overflow(overflow)
  );

  int n_cmp = 0, n_bad = 0;
  logic [79:0] exp_mem[$];
  logic [50:0] exp_desc[$];

  // behavioural model state
  int          md_st = 0;         // 0 seek, 1 post
  int          md_pre = 0, md_post = 0, md_q = 0;
  bit          md_halt = 0, md_hold = 0, stall_en = 0;
  logic [15:0] md_addr = 0, md_start = 0;
  logic [18:0] md_tp = 0;

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic model_done(input logic [15:0] e);
    exp_desc.push_back({md_start, md_tp, e});   // R7: next starts after e
    md_start = e + 16'd1;
    md_pre = 0; md_post = 0; md_st = 0;
    if (md_hold) begin
      md_q++;
      if (md_q == DEPTH) md_halt = 1;            // R9
    end
  endtask

  task automatic model_word(input logic [63:0] d, input logic [7:0] t);
    logic [2:0] idx;
    idx = 3'd0;
    for (int i = 7; i >= 0; i--) if (t[i]) idx = 3'(i);   // R1 lowest wins
    if (md_halt) return;                                  // R9 discarded
    exp_mem.push_back({md_addr, d});                      // R2
    if (md_st == 0) begin
      if (md_pre >= int'(cfg_pre) && t != 0) begin        // R4 / R5
        md_tp = {md_addr, idx};
        if (cfg_post == 0) model_done(md_addr);
        else begin md_st = 1; md_post = 0; end
      end else if (md_pre < int'(cfg_pre)) md_pre++;
    end else begin
      if (md_post + 1 >= int'(cfg_post)) model_done(md_addr);  // R6
      else md_post++;
    end
    md_addr = md_addr + 16'd1;
  endtask

  task automatic send(input logic [63:0] d, input logic [7:0] t);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_trig = t;
    forever begin
      #2;
      if (s_ready) break;
      @(negedge clk);
    end
    model_word(d, t);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // memory-side back-pressure
  initial forever begin
    @(negedge clk);
    m_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
  end

  // memory monitor (R2, R3)
  initial begin
    logic        was_stall = 0;
    logic [79:0] held = '0, e;
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (was_stall) check("R3 hold", {m_valid, m_addr, m_data}, {1'b1, held});
        was_stall = m_valid && !m_ready;
        held = {m_addr, m_data};
        if (m_valid && m_ready) begin
          if (exp_mem.size() == 0) check("R9 unexpected write", {m_addr, m_data}, '1);
          else begin e = exp_mem.pop_front(); check("R2 mem word", {m_addr, m_data}, e); end
        end
      end
    end
  end

  // descriptor monitor (R5, R6, R7, R8)
  initial begin
    logic        was_stall = 0;
    logic [50:0] held = '0, e;
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (was_stall) check("R8 desc hold", {d_valid, d_start, d_trig_ptr, d_end}, {1'b1, held});
        was_stall = d_valid && !d_ready;
        held = {d_start, d_trig_ptr, d_end};
        if (d_valid && d_ready) begin
          if (exp_desc.size() == 0) check("R8 unexpected desc", {d_start, d_trig_ptr, d_end}, '1);
          else begin e = exp_desc.pop_front(); check("R5 R6 R7 desc", {d_start, d_trig_ptr, d_end}, e); end
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R10 m_valid", m_valid, 0);
    check("R10 d_valid", d_valid, 0);
    check("R10 overflow", overflow, 0);
    check("R10 s_ready", s_ready, 1);
    rst_n = 1'b1;
    idle(2);

    // R4: tag in pre-trigger word ignored; R5: tag after trigger ignored
    send(64'h0807060504030201, 8'h10);
    send(64'h1111111111111111, 8'h00);
    send(64'h2222222222222222, 8'h24);   // trigger idx 2 at addr 2
    send(64'h3333333333333333, 8'h00);
    send(64'h4444444444444444, 8'h81);   // ignored (post)
    send(64'h5555555555555555, 8'h00);   // end addr 5
    idle(6);

    // mixed traffic with memory stalls
    stall_en = 1;
    for (int k = 0; k < 60; k++)
      send({$urandom, $urandom}, ($urandom % 5 == 0) ? 8'($urandom) : 8'h00);
    stall_en = 0;
    idle(30);

    // R4 pre=0, R6 post=0: trigger word alone, R1 index corners
    cfg_pre = 0; cfg_post = 0;
    idle(2);
    send(64'hA0A0A0A0A0A0A0A0, 8'h80);   // idx 7
    send(64'hA1A1A1A1A1A1A1A1, 8'h01);   // idx 0
    send(64'hA2A2A2A2A2A2A2A2, 8'hFF);   // idx 0
    send(64'hA3A3A3A3A3A3A3A3, 8'h00);
    send(64'hA4A4A4A4A4A4A4A4, 8'h0C);   // idx 2
    idle(10);

    // R9: fill the descriptor list
    cfg_post = 1;
    d_ready = 1'b0; md_hold = 1; md_q = 0;
    idle(2);
    for (int k = 0; k < 12; k++) send({32'hC0DE0000, 32'(k)}, 8'h40);
    idle(10);
    #2;
    check("R9 overflow", overflow, 1);
    check("R9 no write while halted", m_valid, 0);
    check("R9 input drained", s_ready, 1);
    @(negedge clk);
    d_ready = 1'b1;
    idle(12);
    md_hold = 0; md_halt = 0; md_q = 0; md_st = 0; md_pre = 0;
    for (int k = 0; k < 6; k++) send({32'hBEEF0000, 32'(k)}, 8'h02);
    idle(20);
    #2;
    check("R9 overflow sticky", overflow, 1);
    check("R2 all words written", 80'(exp_mem.size()), 80'd0);
    check("R8 all descriptors out", 80'(exp_desc.size()), 80'd0);
    finish_up();
  end
endmodule